// File: doc/BRIEF.md
# Multi-Cycle Quadratic Evaluator

This block evaluates the polynomial x*x + 2*x for an unsigned operand of parameterised width. It keeps the hardware small. There is one arithmetic unit that either adds or multiplies, two working registers, and two operand selectors. A small controller steps them through a fixed four-step schedule. The steps are: capture the operand, square it, double it, and sum the two partial results. All arithmetic wraps modulo 2^N.

A host drives the operand and raises `go`. While `go` is high, the controller advances one step per clock. Lowering `go` at any point freezes both the step and the register contents. The host may then hold the sequence for as long as it needs. When the last step is reached, `done` rises and `result_o` carries the value. The sequence stays there while `go` is low. Raising `go` again starts a fresh evaluation of the operand present at that time.

Top module: `poly_eval`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0. While the unit is idle, changes on `x_i` leave `result_o` at 0.
- R2: When `go` is held high from the idle state, `done_o` rises right after the fourth rising clock edge, and not before.
- R3: When `done_o` is 1, `result_o` equals (x*x + 2*x) mod 2^N. Here x is the operand that was captured, and both the product and the sum are truncated to N bits.
- R4: Every clock edge at which `go` is low leaves the step and both working registers unchanged. A stall of k cycles therefore delays `done_o` by exactly k cycles and does not alter the result.
- R5: The operand is captured at the second counted edge, which is the edge that leaves the first step. Changes on `x_i` after that edge do not affect the result.
- R6: In the final step with `go` low, `done_o` stays 1 and `result_o` stays constant.
- R7: Raising `go` in the final step restarts the schedule. `done_o` falls at the next edge, and the new result appears after four edges in total.
- R8: When `rst_n` goes low, the unit returns to idle at once, without waiting for a clock. `done_o` goes to 0 and `result_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Advance enable; low freezes the sequence |
| x_i | input | N | Unsigned operand |
| result_o | output | N | x*x + 2*x modulo 2^N, valid while done_o is 1 |
| done_o | output | 1 | High in the final step |

## Verification
The bench targets stalls placed inside each of the three working steps. A design that let a register load while `go` was low would double a value twice or square it twice, and the wrong sum would show. A design that missed the freeze would raise `done` early. The bench also flips the operand after capture, which exposes a datapath that still reads `x_i` late. It restarts straight from the final step, where a controller that passed through idle would deliver `done` one cycle late. Finally, it asserts reset mid-run without a clock edge and checks that the outputs clear at once.

// File: rtl/poly_pkg.sv
package poly_pkg;

   // operation select of the shared arithmetic unit
   typedef enum logic {
      OP_ADD = 1'b0,
      OP_MUL = 1'b1
   } alu_op_e;

   // controller steps
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_LOAD = 3'd1,
      ST_SQR  = 3'd2,
      ST_DBL  = 3'd3,
      ST_SUM  = 3'd4
   } step_e;

   // operand A selector codes
   localparam logic SELA_X  = 1'b0;
   localparam logic SELA_RA = 1'b1;

   // operand B selector codes
   localparam logic [1:0] SELB_ZERO = 2'd0;
   localparam logic [1:0] SELB_RA   = 2'd1;
   localparam logic [1:0] SELB_RB   = 2'd2;

   // control word issued every cycle
   typedef struct packed {
      logic       sel_a;
      logic [1:0] sel_b;
      alu_op_e    op;
      logic       ld_ra;
      logic       ld_rb;
      logic       done;
   } ctrl_t;

endpackage

// File: rtl/poly_opmux.sv
module poly_opmux #(
   parameter int N    = 8,
   parameter int WAYS = 2,
   localparam int SW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0][N-1:0] d_i,
   input  logic [SW-1:0]          sel_i,
   output logic [N-1:0]           y_o
);

   if (WAYS < 1) begin : g_bad_ways
      $error("poly_opmux: WAYS must be at least 1");
   end

   if (WAYS == 1) begin : g_single
      assign y_o = d_i[0];
   end else begin : g_multi
      always_comb begin
         y_o = '0;
         for (int k = 0; k < WAYS; k++) begin
            if (int'(sel_i) == k) y_o = d_i[k];
         end
      end
   end

endmodule

// File: rtl/poly_alu.sv
module poly_alu
   import poly_pkg::*;
#(
   parameter int N        = 8,
   parameter int MUL_IMPL = 1   // 0: inferred multiply, 1: unrolled shift-add
) (
   input  alu_op_e      op_i,
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   output logic [N-1:0] y_o
);

   logic [N-1:0] sum_w;
   logic [N-1:0] prod_w;

   if (MUL_IMPL != 0 && MUL_IMPL != 1) begin : g_bad_impl
      $error("poly_alu: MUL_IMPL must be 0 or 1");
   end

   assign sum_w = a_i + b_i;

   if (MUL_IMPL == 0) begin : g_mul_infer
      logic [2*N-1:0] full_w;
      assign full_w = a_i * b_i;
      assign prod_w = full_w[N-1:0];
   end else begin : g_mul_shift
      // running partial sums, only the low N bits are ever needed
      logic [N:0][N-1:0] acc;
      assign acc[0] = '0;
      for (genvar i = 0; i < N; i++) begin : g_row
         assign acc[i+1] = acc[i] + (b_i[i] ? (a_i << i) : '0);
      end
      assign prod_w = acc[N];
   end

   assign y_o = (op_i == OP_MUL) ? prod_w : sum_w;

endmodule

// File: rtl/poly_ctrl.sv
module poly_ctrl
   import poly_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  go,
   output ctrl_t ctrl_o
);

   step_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d = st_q;
      if (go) begin
         unique case (st_q)
            ST_IDLE: st_d = ST_LOAD;
            ST_LOAD: st_d = ST_SQR;
            ST_SQR:  st_d = ST_DBL;
            ST_DBL:  st_d = ST_SUM;
            ST_SUM:  st_d = ST_LOAD;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ctrl_o       = '0;
      ctrl_o.sel_a = SELA_RA;
      ctrl_o.sel_b = SELB_RB;
      ctrl_o.op    = OP_ADD;
      unique case (st_q)
         ST_LOAD: begin
            ctrl_o.sel_a = SELA_X;
            ctrl_o.sel_b = SELB_ZERO;
            ctrl_o.ld_ra = go;
            ctrl_o.ld_rb = go;
         end
         ST_SQR: begin
            ctrl_o.op    = OP_MUL;
            ctrl_o.ld_rb = go;
         end
         ST_DBL: begin
            ctrl_o.sel_b = SELB_RA;
            ctrl_o.ld_ra = go;
         end
         ST_SUM:  ctrl_o.done = 1'b1;
         default: ;
      endcase
   end

   // R4: a low go freezes the step
   p_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> $stable(st_q));

   // R2: schedule order under go
   p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && st_q == ST_LOAD) |=> st_q == ST_SQR);

   // R7: restart goes straight to the load step
   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (go && st_q == ST_SUM) |=> st_q == ST_LOAD);

   // R2: completion only entered from the doubling step
   p_done_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_o.done) |-> $past(st_q) == ST_DBL);

endmodule

// File: rtl/poly_eval.sv
module poly_eval
   import poly_pkg::*;
#(
   parameter int N        = 8,
   parameter int MUL_IMPL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [N-1:0] x_i,
   output logic [N-1:0] result_o,
   output logic         done_o
);

   localparam int WAYS_A = 2;
   localparam int WAYS_B = 3;
   localparam int SW_A   = $clog2(WAYS_A);
   localparam int SW_B   = $clog2(WAYS_B);

   if (N < 2 || N > 32) begin : g_bad_width
      $error("poly_eval: N must lie in 2..32");
   end

   ctrl_t        ctl;
   logic [N-1:0] ra_q, rb_q, opa, opb, alu_y;
   logic [WAYS_A-1:0][N-1:0] mux_a_in;
   logic [WAYS_B-1:0][N-1:0] mux_b_in;
   logic [SW_A-1:0] sel_a_w;
   logic [SW_B-1:0] sel_b_w;

   poly_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .ctrl_o (ctl)
   );

   assign mux_a_in[0] = x_i;
   assign mux_a_in[1] = ra_q;
   assign sel_a_w     = SW_A'(ctl.sel_a);

   assign mux_b_in[0] = '0;
   assign mux_b_in[1] = ra_q;
   assign mux_b_in[2] = rb_q;
   assign sel_b_w     = SW_B'(ctl.sel_b);

   poly_opmux #(.N(N), .WAYS(WAYS_A)) u_mux_a (
      .d_i   (mux_a_in),
      .sel_i (sel_a_w),
      .y_o   (opa)
   );

   poly_opmux #(.N(N), .WAYS(WAYS_B)) u_mux_b (
      .d_i   (mux_b_in),
      .sel_i (sel_b_w),
      .y_o   (opb)
   );

   poly_alu #(.N(N), .MUL_IMPL(MUL_IMPL)) u_alu (
      .op_i (ctl.op),
      .a_i  (opa),
      .b_i  (opb),
      .y_o  (alu_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ra_q <= '0;
      else if (ctl.ld_ra) ra_q <= alu_y;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rb_q <= '0;
      else if (ctl.ld_rb) rb_q <= alu_y;
   end

   assign result_o = alu_y;
   assign done_o   = ctl.done;

   // R4: no register changes while go is low
   p_reg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> ($stable(ra_q) && $stable(rb_q)));

   // R5: the load step copies the operand into both registers
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !done_o && $past(done_o) == 1'b0 && ctl.sel_b == SELB_ZERO && ctl.ld_ra)
      |=> (ra_q == $past(x_i) && rb_q == $past(x_i)));

   // R3: squaring step leaves RA alone and writes its square into RB
   p_square_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.op == OP_MUL && go)
      |=> (rb_q == N'($past(ra_q) * $past(ra_q)) && $stable(ra_q)));

   // R6: result frozen while held in the final step
   p_done_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !go) |=> (done_o && $stable(result_o)));

endmodule

// File: tb/sim_poly_eval.sv
module sim_poly_eval;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         go = 1'b0;
   logic [N-1:0] x_i = '0;
   logic [N-1:0] result_o;
   logic         done_o;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;   // 250 MHz

   poly_eval #(.N(N)) u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (go),
      .x_i      (x_i),
      .result_o (result_o),
      .done_o   (done_o)
   );

   function automatic logic [N-1:0] ref_f(input logic [N-1:0] x);
      longint unsigned v;
      v = longint'(x);
      return N'(v * v + 2 * v);
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one full evaluation; stall_at in 2..4 inserts stall_len low-go cycles before that edge
   task automatic run_seq(input logic [N-1:0] x, input int stall_at,
                          input int stall_len, input bit flip_x);
      x_i = x;
      go  = 1'b1;
      for (int k = 1; k <= 4; k++) begin
         if (k == stall_at) begin
            go = 1'b0;
            for (int s = 0; s < stall_len; s++) begin
               @(posedge clk); @(negedge clk);
               chk("R4 done during stall", done_o, 0);
               if (flip_x && k >= 3) x_i = ~x_i;
            end
            go = 1'b1;
         end
         @(posedge clk); @(negedge clk);
         if (k == 2 && flip_x) x_i = ~x;  // R5: after capture
         if (k < 4) chk("R2 done early", done_o, 0);
         else begin
            chk("R2 done at fourth edge", done_o, 1);
            chk("R3 result", result_o, ref_f(x));
         end
      end
      go = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; go = 1'b0; x_i = 8'h5a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 done after reset", done_o, 0);
      chk("R1 result after reset", result_o, 0);
      x_i = 8'hc3;
      @(posedge clk); @(negedge clk);
      chk("R1 idle ignores x", result_o, 0);
   endtask

   task automatic t_basic();
      run_seq(8'd3, 0, 0, 1'b0);
      run_seq(8'd0, 0, 0, 1'b0);
      run_seq(8'd255, 0, 0, 1'b0);   // R3 wrap: 255*255+510 mod 256
      run_seq(8'd16, 0, 0, 1'b0);
   endtask

   task automatic t_stalls();
      run_seq(8'd7, 2, 3, 1'b0);     // R4 stall in load step
      run_seq(8'd9, 3, 2, 1'b0);     // R4 stall in square step
      run_seq(8'd200, 4, 5, 1'b0);   // R4 stall in double step
   endtask

   task automatic t_xchange();
      run_seq(8'd11, 0, 0, 1'b1);    // R5
      run_seq(8'd37, 3, 4, 1'b1);    // R5 with stall
   endtask

   task automatic t_hold_done();
      logic [N-1:0] r;
      run_seq(8'd21, 0, 0, 1'b0);
      r = result_o;
      for (int i = 0; i < 5; i++) begin
         @(posedge clk); @(negedge clk);
         chk("R6 done held", done_o, 1);
         chk("R6 result held", result_o, r);
      end
   endtask

   task automatic t_restart();
      // starts in the final step; run_seq checks done drops after the first edge
      run_seq(8'd100, 0, 0, 1'b0);   // R7
      run_seq(8'd101, 0, 0, 1'b0);   // R7 back to back
   endtask

   task automatic t_async_reset();
      x_i = 8'd45; go = 1'b1;
      repeat (3) begin @(posedge clk); @(negedge clk); end
      #0.5 rst_n = 1'b0;
      #0.5;
      chk("R8 done cleared", done_o, 0);
      chk("R8 result cleared", result_o, 0);
      go = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_seq(8'd45, 0, 0, 1'b0);    // R8 clean run afterwards
   endtask

   task automatic t_random();
      for (int i = 0; i < 20; i++) begin
         logic [N-1:0] xr;
         int sa;
         xr = N'($urandom);
         sa = (i % 2 == 0) ? 0 : int'($urandom_range(2, 4));
         run_seq(xr, sa, int'($urandom_range(1, 6)), i[2]);  // R3 R4
      end
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_stalls();
      t_xchange();
      t_hold_done();
      t_restart();
      t_async_reset();
      t_random();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule